// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block is the data pointer register file of an 8052-style microcontroller core. It holds two independent 16-bit pointers. Software reaches each pointer's low and high bytes through special-function-register (SFR) addresses. A one-bit select register sets which pointer is active. The CPU sequencer sends pointer operations to the active pointer through a strobe and an opcode. The operations are load a 16-bit immediate, increment and decrement. The active pointer is always presented, registered, as the address for external data moves.

The first pointer keeps the classic byte pair addresses. The second pointer sits on two addresses that a classic map leaves empty. The select register sits on the next free address. Opcode decoding is limited to the three pointer opcodes; all other instruction handling lives elsewhere in the core.

Top module: `ddp_unit`

## Requirements
- R1: After synchronous reset both pointers are 0x0000, the select bit is 0, `ptr_q` is 0x0000, `sfr_rdata` is 0x00 and `sfr_hit` is 0.
- R2: SFR map: pointer 0 low byte at 0x82, high byte at 0x83; pointer 1 low byte at 0x84, high byte at 0x85; select register at 0x86 with the select in bit 0. A write with `sfr_we` updates that byte at the clock edge. A read with `sfr_re` returns the value held before that edge on `sfr_rdata`, with `sfr_hit` set, in the following cycle.
- R3: `ptr_q` always equals the pointer chosen by the select bit (0 = pointer 0, 1 = pointer 1), updated at the same edge as the state it reflects.
- R4: With `op_valid` and `op_code` 0xA3 the active pointer increments by one, with the carry from the low byte into the high byte in the same cycle; 0xFFFF wraps to 0x0000.
- R5: With `op_valid` and `op_code` 0xA5 the active pointer decrements by one, with the borrow into the high byte in the same cycle; 0x0000 wraps to 0xFFFF.
- R6: With `op_valid` and `op_code` 0x90 the active pointer is loaded with `op_data`.
- R7: The pointer that is not selected keeps its value during any operation on the active one.
- R8: Any other `op_code`, or any opcode without `op_valid`, leaves both pointers unchanged.
- R9: When an operation and an SFR write arrive in the same cycle, the operation targets the pointer selected before the edge. It overrides any byte write to that pointer. A write to the other pointer's bytes or to the select register still takes effect.
- R10: Reads of the select register return 0 in bits 7..1. A read of any address outside 0x82..0x86 returns 0x00 with `sfr_hit` low. With `sfr_re` low, `sfr_rdata` is 0x00 and `sfr_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_re | input | 1 | SFR read strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered SFR read data |
| sfr_hit | output | 1 | Registered flag: the last read hit a mapped address |
| op_valid | input | 1 | Pointer operation strobe |
| op_code | input | 8 | Pointer operation opcode |
| op_data | input | 16 | Immediate for the load operation |
| ptr_q | output | 16 | Registered active pointer |

## Verification
The bench steps the increment across 0x00FF and 0xFFFF and the decrement across 0x0100 and 0x0000. A design with an 8-bit adder, or a carry taken one cycle late, shows a wrong high byte there. The bench also fires operations in the same cycle as select writes and byte writes. A design that uses the new select, or lets the SFR write win, modifies the wrong pointer or loses the result. The idle pointer is read back after every kind of operation on the other one, which exposes a design that writes both pointers. Unmapped addresses and the upper select bits are read to catch stray decode.

// File: rtl/ddp_pkg.sv
package ddp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 2 * BYTE_W;
  localparam int unsigned N_PTR  = 2;
  localparam int unsigned SEL_W  = (N_PTR > 1) ? $clog2(N_PTR) : 1;

  typedef enum logic [1:0] {
    PO_NONE = 2'd0,
    PO_INC  = 2'd1,
    PO_DEC  = 2'd2,
    PO_LOAD = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/ddp_opdec.sv
module ddp_opdec
  import ddp_pkg::*;
#(
  parameter logic [7:0] OPC_INC  = 8'hA3,
  parameter logic [7:0] OPC_DEC  = 8'hA5,
  parameter logic [7:0] OPC_LOAD = 8'h90
) (
  input  logic       valid,
  input  logic [7:0] code,
  output ptr_op_e    op
);
  always_comb begin
    op = PO_NONE;
    if (valid) begin
      unique case (code)
        OPC_INC:  op = PO_INC;
        OPC_DEC:  op = PO_DEC;
        OPC_LOAD: op = PO_LOAD;
        default:  op = PO_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ddp_step.sv
module ddp_step
  import ddp_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  ptr_op_e      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] imm,
  output logic [W-1:0] nxt
);
  logic [W-1:0] delta;

  // One full-width adder serves both directions: +1 or +(all ones)
  always_comb begin
    delta = (op == PO_DEC) ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
    unique case (op)
      PO_INC, PO_DEC: nxt = cur + delta;
      PO_LOAD:        nxt = imm;
      default:        nxt = cur;
    endcase
  end
endmodule

// File: rtl/ddp_bank.sv
module ddp_bank
  import ddp_pkg::*;
#(
  parameter int unsigned NP = N_PTR,
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned PW = 2 * BW,
  localparam int unsigned SW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NP-1:0]        we_lo,
  input  logic [NP-1:0]        we_hi,
  input  logic [BW-1:0]        wbyte,
  input  logic                 op_en,
  input  logic [PW-1:0]        op_val,
  input  logic [SW-1:0]        sel_cur,
  input  logic [SW-1:0]        sel_nxt,
  output logic [NP-1:0][PW-1:0] ptrs,
  output logic [PW-1:0]        act_q
);
  logic [NP-1:0][PW-1:0] p_q;
  logic [NP-1:0][PW-1:0] p_d;

  for (genvar gi = 0; gi < NP; gi++) begin : g_ptr
    always_comb begin
      p_d[gi] = p_q[gi];
      if (op_en && (sel_cur == SW'(gi))) begin
        p_d[gi] = op_val;
      end else begin
        if (we_lo[gi]) p_d[gi][BW-1:0]  = wbyte;
        if (we_hi[gi]) p_d[gi][PW-1:BW] = wbyte;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) p_q[gi] <= '0;
      else     p_q[gi] <= p_d[gi];
    end

    AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!(op_en && sel_cur == SW'(gi)) && !we_lo[gi] && !we_hi[gi]) |=> $stable(p_q[gi])); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= p_d[sel_nxt];
  end

  assign ptrs = p_q;
endmodule

// File: rtl/ddp_unit.sv
module ddp_unit
  import ddp_pkg::*;
#(
  parameter logic [7:0] ADDR_P0_LO = 8'h82,
  parameter logic [7:0] ADDR_P0_HI = 8'h83,
  parameter logic [7:0] ADDR_P1_LO = 8'h84,
  parameter logic [7:0] ADDR_P1_HI = 8'h85,
  parameter logic [7:0] ADDR_SEL   = 8'h86,
  parameter logic [7:0] OPC_INC    = 8'hA3,
  parameter logic [7:0] OPC_DEC    = 8'hA5,
  parameter logic [7:0] OPC_LOAD   = 8'h90
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sfr_we,
  input  logic        sfr_re,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  output logic        sfr_hit,
  input  logic        op_valid,
  input  logic [7:0]  op_code,
  input  logic [15:0] op_data,
  output logic [15:0] ptr_q
);
  localparam logic [N_PTR-1:0][7:0] LO_ADDR = {ADDR_P1_LO, ADDR_P0_LO};
  localparam logic [N_PTR-1:0][7:0] HI_ADDR = {ADDR_P1_HI, ADDR_P0_HI};

  logic [SEL_W-1:0]             sel_q, sel_d;
  logic [N_PTR-1:0]             we_lo, we_hi;
  logic [N_PTR-1:0][PTR_W-1:0]  ptrs;
  ptr_op_e                      op;
  logic [PTR_W-1:0]             op_val;
  logic                         sel_wr;
  logic [7:0]                   rd_mux;
  logic                         rd_map;

  ddp_opdec #(.OPC_INC(OPC_INC), .OPC_DEC(OPC_DEC), .OPC_LOAD(OPC_LOAD)) u_dec (
    .valid (op_valid),
    .code  (op_code),
    .op    (op)
  );

  ddp_step #(.W(PTR_W)) u_step (
    .op  (op),
    .cur (ptrs[sel_q]),
    .imm (op_data),
    .nxt (op_val)
  );

  for (genvar gi = 0; gi < N_PTR; gi++) begin : g_wdec
    assign we_lo[gi] = sfr_we && (sfr_addr == LO_ADDR[gi]);
    assign we_hi[gi] = sfr_we && (sfr_addr == HI_ADDR[gi]);
  end

  assign sel_wr = sfr_we && (sfr_addr == ADDR_SEL);
  assign sel_d  = sel_wr ? sfr_wdata[SEL_W-1:0] : sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end

  ddp_bank #(.NP(N_PTR), .BW(BYTE_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we_lo   (we_lo),
    .we_hi   (we_hi),
    .wbyte   (sfr_wdata),
    .op_en   (op != PO_NONE),
    .op_val  (op_val),
    .sel_cur (sel_q),
    .sel_nxt (sel_d),
    .ptrs    (ptrs),
    .act_q   (ptr_q)
  );

  always_comb begin
    rd_mux = '0;
    rd_map = 1'b0;
    if (sfr_addr == ADDR_SEL) begin
      rd_mux = {{(8-SEL_W){1'b0}}, sel_q};
      rd_map = 1'b1;
    end
    for (int i = 0; i < N_PTR; i++) begin
      if (sfr_addr == LO_ADDR[i]) begin
        rd_mux = ptrs[i][BYTE_W-1:0];
        rd_map = 1'b1;
      end
      if (sfr_addr == HI_ADDR[i]) begin
        rd_mux = ptrs[i][PTR_W-1:BYTE_W];
        rd_map = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata <= '0;
      sfr_hit   <= 1'b0;
    end else begin
      sfr_rdata <= sfr_re ? rd_mux : 8'h00;
      sfr_hit   <= sfr_re && rd_map;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ptr_q == 16'h0000 && sfr_rdata == 8'h00 && !sfr_hit)); // R1

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_INC && !sel_wr) |=> (ptr_q == 16'($past(ptr_q) + 16'd1))); // R4

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_DEC && !sel_wr) |=> (ptr_q == 16'($past(ptr_q) - 16'd1))); // R5

  AST_LOAD_IMM: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_LOAD && !sel_wr) |=> (ptr_q == $past(op_data))); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sfr_re || !rd_map) |=> (sfr_rdata == 8'h00 && !sfr_hit)); // R10
endmodule

// File: tb/sim_ddp_unit.sv
module sim_ddp_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        sfr_we, sfr_re, op_valid;
  logic [7:0]  sfr_addr, sfr_wdata, op_code;
  logic [15:0] op_data;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic [15:0] ptr_q;

  int total = 0;
  int bad   = 0;

  int m_p [2];
  int m_sel;
  int m_rd;
  int m_hit;
  int m_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddp_unit u0 (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_re(sfr_re),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .sfr_hit(sfr_hit), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .ptr_q(ptr_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: evaluated once per rising edge from stable inputs
  task automatic model_edge();
    int np [2];
    int nsel;
    int a;
    np[0] = m_p[0];
    np[1] = m_p[1];
    nsel  = m_sel;
    a     = int'(sfr_addr);
    m_hit = 0;
    m_rd  = 0;
    if (sfr_re) begin
      m_hit = 1;
      case (a)
        'h82: m_rd = m_p[0] % 256;
        'h83: m_rd = m_p[0] / 256;
        'h84: m_rd = m_p[1] % 256;
        'h85: m_rd = m_p[1] / 256;
        'h86: m_rd = m_sel;
        default: m_hit = 0;
      endcase
    end
    if (sfr_we) begin
      case (a)
        'h82: np[0] = (m_p[0] / 256) * 256 + int'(sfr_wdata);
        'h83: np[0] = int'(sfr_wdata) * 256 + (m_p[0] % 256);
        'h84: np[1] = (m_p[1] / 256) * 256 + int'(sfr_wdata);
        'h85: np[1] = int'(sfr_wdata) * 256 + (m_p[1] % 256);
        'h86: nsel  = int'(sfr_wdata) % 2;
        default: ;
      endcase
    end
    if (op_valid) begin
      case (op_code)
        8'hA3: np[m_sel] = (m_p[m_sel] + 1) % 65536;
        8'hA5: np[m_sel] = (m_p[m_sel] + 65535) % 65536;
        8'h90: np[m_sel] = int'(op_data);
        default: ;
      endcase
    end
    m_p[0] = np[0];
    m_p[1] = np[1];
    m_sel  = nsel;
    m_q    = np[nsel];
  endtask

  task automatic step(input logic we, input logic re, input logic [7:0] a,
                      input logic [7:0] wd, input logic ov, input logic [7:0] oc,
                      input logic [15:0] od, input string tag);
    sfr_we = we; sfr_re = re; sfr_addr = a; sfr_wdata = wd;
    op_valid = ov; op_code = oc; op_data = od;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " ptr_q"}, int'(ptr_q), m_q);
    check({tag, " rdata"}, int'(sfr_rdata), m_rd);
    check({tag, " hit"}, int'(sfr_hit), m_hit);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, 8'h00, 16'h0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 8'h00, 16'h0, tag);
  endtask
  task automatic op(input logic [7:0] c, input logic [15:0] d, input string tag);
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, c, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    sfr_we = 0; sfr_re = 0; sfr_addr = 0; sfr_wdata = 0;
    op_valid = 0; op_code = 0; op_data = 0;
    m_p[0] = 0; m_p[1] = 0; m_sel = 0; m_rd = 0; m_hit = 0; m_q = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ptr_q", int'(ptr_q), 0);
    check("R1 rdata", int'(sfr_rdata), 0);
    check("R1 hit", int'(sfr_hit), 0);
    rd(8'h84, "R1 p1 lo");
    rd(8'h86, "R1 sel");

    // R2 map write/read
    wr(8'h82, 8'h34, "R2 p0 lo");
    wr(8'h83, 8'h12, "R2 p0 hi");
    wr(8'h84, 8'hCD, "R2 p1 lo");
    wr(8'h85, 8'hAB, "R2 p1 hi");
    rd(8'h82, "R2 rd p0 lo");
    rd(8'h83, "R2 rd p0 hi");
    rd(8'h84, "R2 rd p1 lo");
    rd(8'h85, "R2 rd p1 hi");

    // R3 select
    wr(8'h86, 8'h01, "R3 sel to 1");
    check("R3 ptr_q p1", int'(ptr_q), 'hABCD);
    wr(8'h86, 8'hFE, "R3 sel to 0");
    check("R3 ptr_q p0", int'(ptr_q), 'h1234);
    wr(8'h86, 8'hFF, "R10 sel upper");
    rd(8'h86, "R10 sel upper read");
    check("R10 sel read", int'(sfr_rdata), 1);

    // R4 increment with carry and wrap on pointer 1
    op(8'h90, 16'h00FF, "R6 load p1");
    op(8'hA3, 16'h0, "R4 carry");
    check("R4 carry value", int'(ptr_q), 'h0100);
    op(8'h90, 16'hFFFF, "R6 load max");
    op(8'hA3, 16'h0, "R4 wrap");
    check("R4 wrap value", int'(ptr_q), 0);
    // R5 decrement with borrow and wrap
    op(8'hA5, 16'h0, "R5 wrap");
    check("R5 wrap value", int'(ptr_q), 'hFFFF);
    op(8'h90, 16'h0100, "R6 load");
    op(8'hA5, 16'h0, "R5 borrow");
    check("R5 borrow value", int'(ptr_q), 'h00FF);
    // R7 idle pointer 0 untouched
    rd(8'h82, "R7 p0 lo");
    check("R7 p0 lo value", int'(sfr_rdata), 'h34);
    rd(8'h83, "R7 p0 hi");
    check("R7 p0 hi value", int'(sfr_rdata), 'h12);
    // R8 other opcodes
    op(8'hA4, 16'h5555, "R8 A4");
    op(8'h00, 16'h5555, "R8 00");
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'hA3, 16'h0, "R8 no valid");
    check("R8 held", int'(ptr_q), 'h00FF);
    // R9 collisions
    step(1'b1, 1'b0, 8'h86, 8'h00, 1'b1, 8'hA3, 16'h0, "R9 sel+op");
    check("R9 p0 shown", int'(ptr_q), 'h1234);
    rd(8'h84, "R9 p1 lo");
    check("R9 p1 lo incremented", int'(sfr_rdata), 'h00);
    step(1'b1, 1'b0, 8'h82, 8'h77, 1'b1, 8'hA5, 16'h0, "R9 wr+op");
    check("R9 op wins", int'(ptr_q), 'h1233);
    step(1'b1, 1'b0, 8'h85, 8'h99, 1'b1, 8'hA3, 16'h0, "R9 other wr");
    rd(8'h85, "R9 other hi");
    check("R9 other hi value", int'(sfr_rdata), 'h99);
    // R10 unmapped
    rd(8'h81, "R10 unmapped 81");
    rd(8'h87, "R10 unmapped 87");
    step(1'b0, 1'b0, 8'h82, 8'h00, 1'b0, 8'h00, 16'h0, "R10 no re");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [7:0] c;
      a = 8'h80 + 8'($urandom_range(0, 7));
      case ($urandom_range(0, 4))
        0: c = 8'hA3;
        1: c = 8'hA5;
        2: c = 8'h90;
        3: c = 8'h00;
        default: c = 8'hA4;
      endcase
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), c,
           16'($urandom_range(0, 65535)), "R3 R7 R9 mixed");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule